// File: doc/BRIEF.md
# Display Controller Serial Command Interface

This block is the serial slave that sits between a host and a vacuum-fluorescent display controller. The host frames each transaction with an active-low chip select and supplies its own serial clock. A single data line is shared in both directions. Every edge on the serial clock and data inputs is qualified by a faster local sampling clock, so short glitches never reach the bit logic.

Each frame starts with an output phase. The block drives one filler byte and then four converter result bytes, channel 0 first. After that the same pin turns around and becomes an input. Input bytes are decoded as commands that set the display, dimmer, scan-count and port registers. Once a display-data command arrives, every following byte in the frame is instead written to the display RAM. The bytes are packed three or four per scan timing, starting at the highest timing and walking down to the lowest. Raising chip select ends the frame and clears all byte and bit state.

Top module: `vfd_serial_if`

## Requirements
- R1: Serial bits are taken on rising serial-clock edges, least-significant bit first, and each complete input-phase byte is decoded exactly once.
- R2: `sdata_oe_o` is 0 whenever chip select is high, and it also stays 0 for the rest of the frame once the output phase has ended.
- R3: A level on the serial clock or data input is accepted only after two successive sampling-clock samples agree. A one-sample pulse on the serial clock does not count as an edge.
- R4: After chip select falls, the block drives five bytes. The first is a 0x00 filler. Then follow the result bytes for channels 0, 1, 2 and 3, taken from `ad_data_i[8c+7:8c]` as they stood when chip select fell. The sixth byte is the first input byte.
- R5: Bits 7..5 of a command byte select its kind: 111 display data, 110 display state, 101 timing count, 100 port data. Any byte with bit 7 = 0 changes no register.
- R6: A display-state command loads the display enable from bit 4 and the dimmer code from bits 3..2. Bits 1..0 are held as a pending port-mode code, and `port_mode_o` does not change.
- R7: A port-data command loads `port_data_o` from bits 2..0 and copies the pending port-mode code to `port_mode_o`. Nothing else changes `port_mode_o`.
- R8: A timing-count command loads code c from bits 3..0. The scan uses 16-c timings, with indices 15-c down to 0.
- R9: A display-data command loads the byte-width flag from bit 4 (1 = three bytes per timing) and the digit start code from bits 3..0. Every later byte of that frame is written to the RAM and none is decoded as a command.
- R10: The RAM address is timing*4 + slot. Writes start at timing 15-c, slot 0. The slot counts 0..3, or 0..2 in three-byte mode, and the timing then steps down. After timing 0 the walk wraps back to timing 15-c.
- R11: A rising chip select discards any partial byte. The next frame starts again with the filler byte of the output phase.
- R12: After reset the outputs are: display off, dimmer 0, port mode 3, port data 0, timing code 0, four-byte mode, digit start 0, and no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_i | input | 1 | Serial data from the pin |
| sdata_o | output | 1 | Serial data to the pin |
| sdata_oe_o | output | 1 | Pin drive enable (pad is high-impedance when 0) |
| ad_data_i | input | 32 | Converter results, channel c in bits 8c+7..8c |
| disp_on_o | output | 1 | Display enable |
| duty_code_o | output | 2 | Dimmer duty code |
| port_mode_o | output | 2 | Active digit/port mode code |
| port_data_o | output | 3 | General output port bits |
| timing_code_o | output | 4 | Timing-count code c |
| three_byte_o | output | 1 | 1 = three bytes per timing |
| digit_start_o | output | 4 | Digit start code |
| ram_we_o | output | 1 | Display RAM write strobe |
| ram_addr_o | output | 6 | Display RAM address |
| ram_wdata_o | output | 8 | Display RAM write data |

## Verification
Several rules are checked by the assertions on every cycle:
- the filtered level changes only after two agreeing samples;
- a byte strobe lasts one cycle and never occurs while the pin is driven;
- a rising chip select clears the counters and the drive enable;
- RAM writes occur only in display-data mode and stay inside the active timing range;
- the port mode moves only on a port-data command.

The bench scenarios are needed for the rest: the filler and channel byte order, LSB-first command fields, the descending address walk with its wrap in both byte widths, glitch rejection mid-byte, and partial-byte discard across frames.

// File: rtl/vfd_serial_pkg.sv
package vfd_serial_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    CMD_PORT    = 3'b100,
    CMD_TIMING  = 3'b101,
    CMD_STATE   = 3'b110,
    CMD_DISPLAY = 3'b111
  } cmd_kind_e;
endpackage

// File: rtl/vfd_glitch_filter.sv
module vfd_glitch_filter #(
  parameter int unsigned WIDTH       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] filt_o
);
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic [WIDTH-1:0] hist_q;
  logic [WIDTH-1:0] filt_q;
  logic [WIDTH-1:0] last;

  assign last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      hist_q <= '0;
      filt_q <= '0;
    end else begin
      sync_q[0] <= raw_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      hist_q <= last;
      for (int b = 0; b < WIDTH; b++)
        if (last[b] == hist_q[b]) filt_q[b] <= last[b];
    end
  end

  assign filt_o = filt_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    AST_FILTER_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_q[g] != $past(filt_q[g])) |-> $past(last[g] == hist_q[g])); // R3
  end
endmodule

// File: rtl/vfd_serial_engine.sv
module vfd_serial_engine
  import vfd_serial_pkg::*;
#(
  parameter int unsigned AD_CH     = 4,
  parameter int unsigned OUT_BYTES = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    sclk_f_i,
  input  logic                    sdata_f_i,
  input  logic [AD_CH*BYTE_W-1:0] ad_data_i,
  output logic                    sdata_o,
  output logic                    sdata_oe_o,
  output logic                    rx_valid_o,
  output logic [BYTE_W-1:0]       rx_byte_o,
  output logic                    frame_o
);
  localparam int unsigned LEAD  = OUT_BYTES - AD_CH;
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam int unsigned CNT_W = $clog2(OUT_BYTES + 1);

  logic [1:0]                cs_sync_q;
  logic                      cs_s;
  logic                      sclk_prev_q;
  logic                      rise;
  logic [BIT_W-1:0]          bit_cnt_q;
  logic [CNT_W-1:0]          byte_cnt_q;
  logic [BYTE_W-1:0]         rx_sr_q;
  logic [BYTE_W-1:0]         rx_byte_q;
  logic                      rx_valid_q;
  logic [AD_CH*BYTE_W-1:0]   ad_snap_q;
  logic                      sdata_q;
  logic                      sdata_oe_q;
  logic                      in_phase;
  logic [BYTE_W-1:0]         tx_byte;

  assign cs_s     = cs_sync_q[1];
  assign rise     = sclk_f_i & ~sclk_prev_q;
  assign in_phase = (byte_cnt_q == CNT_W'(OUT_BYTES));

  always_comb begin
    tx_byte = '0;
    for (int c = 0; c < AD_CH; c++)
      if (byte_cnt_q == CNT_W'(LEAD + c)) tx_byte = ad_snap_q[c*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync_q   <= 2'b11;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_sync_q   <= {cs_sync_q[0], cs_ni};
      sclk_prev_q <= sclk_f_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_sr_q    <= '0;
      rx_byte_q  <= '0;
      rx_valid_q <= 1'b0;
      ad_snap_q  <= '0;
      sdata_q    <= 1'b0;
      sdata_oe_q <= 1'b0;
    end else if (cs_s) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_valid_q <= 1'b0;
      ad_snap_q  <= ad_data_i;
      sdata_q    <= 1'b0;
      sdata_oe_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      sdata_oe_q <= ~in_phase;
      sdata_q    <= ~in_phase & tx_byte[bit_cnt_q];
      if (rise) begin
        rx_sr_q   <= {sdata_f_i, rx_sr_q[BYTE_W-1:1]};
        bit_cnt_q <= bit_cnt_q + BIT_W'(1);
        if (bit_cnt_q == BIT_W'(BYTE_W - 1)) begin
          if (in_phase) begin
            rx_valid_q <= 1'b1;
            rx_byte_q  <= {sdata_f_i, rx_sr_q[BYTE_W-1:1]};
          end else begin
            byte_cnt_q <= byte_cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign sdata_o    = sdata_q;
  assign sdata_oe_o = sdata_oe_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_byte_q;
  assign frame_o    = ~cs_s;

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |=> !rx_valid_q); // R1
  AST_OE_OFF_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s) |=> !sdata_oe_q); // R2
  AST_NO_RX_WHILE_DRIVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |-> !sdata_oe_q); // R4
  AST_CS_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s) |=> (bit_cnt_q == '0 && byte_cnt_q == '0)); // R11
endmodule

// File: rtl/vfd_cmd_decoder.sv
module vfd_cmd_decoder
  import vfd_serial_pkg::*;
#(
  parameter int unsigned MAX_TIMINGS = 16,
  parameter int unsigned SLOTS       = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_i,
  input  logic                  rx_valid_i,
  input  logic [BYTE_W-1:0]     rx_byte_i,
  output logic                  disp_on_o,
  output logic [1:0]            duty_code_o,
  output logic [1:0]            port_mode_o,
  output logic [2:0]            port_data_o,
  output logic [$clog2(MAX_TIMINGS)-1:0] timing_code_o,
  output logic                  three_byte_o,
  output logic [3:0]            digit_start_o,
  output logic                  ram_we_o,
  output logic [$clog2(MAX_TIMINGS)+$clog2(SLOTS)-1:0] ram_addr_o,
  output logic [BYTE_W-1:0]     ram_wdata_o
);
  localparam int unsigned TIDX_W = $clog2(MAX_TIMINGS);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned ADDR_W = TIDX_W + SLOT_W;

  logic              disp_on_q;
  logic [1:0]        duty_q;
  logic [1:0]        mode_pend_q;
  logic [1:0]        mode_q;
  logic [2:0]        port_q;
  logic [TIDX_W-1:0] tcode_q;
  logic              three_q;
  logic [3:0]        dstart_q;
  logic              in_disp_q;
  logic [TIDX_W-1:0] tidx_q;
  logic [SLOT_W-1:0] slot_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [TIDX_W-1:0] first_idx;
  logic [SLOT_W-1:0] last_slot;
  cmd_kind_e         kind;

  assign first_idx = TIDX_W'(MAX_TIMINGS - 1) - tcode_q;
  assign last_slot = three_q ? SLOT_W'(SLOTS - 2) : SLOT_W'(SLOTS - 1);
  assign kind      = cmd_kind_e'(rx_byte_i[BYTE_W-1 -: 3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_on_q   <= 1'b0;
      duty_q      <= '0;
      mode_pend_q <= 2'b11;
      mode_q      <= 2'b11;
      port_q      <= '0;
      tcode_q     <= '0;
      three_q     <= 1'b0;
      dstart_q    <= '0;
      in_disp_q   <= 1'b0;
      tidx_q      <= '0;
      slot_q      <= '0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else begin
      we_q <= 1'b0;
      if (!frame_i) begin
        in_disp_q <= 1'b0;
      end else if (rx_valid_i) begin
        if (in_disp_q) begin
          we_q    <= 1'b1;
          addr_q  <= {tidx_q, slot_q};
          wdata_q <= rx_byte_i;
          if (slot_q == last_slot) begin
            slot_q <= '0;
            tidx_q <= (tidx_q == '0) ? first_idx : tidx_q - TIDX_W'(1);
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end else if (rx_byte_i[BYTE_W-1]) begin
          unique case (kind)
            CMD_DISPLAY: begin
              three_q   <= rx_byte_i[4];
              dstart_q  <= rx_byte_i[3:0];
              in_disp_q <= 1'b1;
              tidx_q    <= first_idx;
              slot_q    <= '0;
            end
            CMD_STATE: begin
              disp_on_q   <= rx_byte_i[4];
              duty_q      <= rx_byte_i[3:2];
              mode_pend_q <= rx_byte_i[1:0];
            end
            CMD_TIMING: tcode_q <= rx_byte_i[TIDX_W-1:0];
            CMD_PORT: begin
              port_q <= rx_byte_i[2:0];
              mode_q <= mode_pend_q;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign disp_on_o     = disp_on_q;
  assign duty_code_o   = duty_q;
  assign port_mode_o   = mode_q;
  assign port_data_o   = port_q;
  assign timing_code_o = tcode_q;
  assign three_byte_o  = three_q;
  assign digit_start_o = dstart_q;
  assign ram_we_o      = we_q;
  assign ram_addr_o    = addr_q;
  assign ram_wdata_o   = wdata_q;

  AST_WE_NEEDS_DISPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(in_disp_q)); // R9
  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (addr_q[ADDR_W-1:SLOT_W] <= first_idx && addr_q[SLOT_W-1:0] <= last_slot)); // R10
  AST_MODE_ON_PORT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(rx_valid_i && !in_disp_q && rx_byte_i[BYTE_W-1 -: 3] == 3'b100)); // R7
endmodule

// File: rtl/vfd_serial_if.sv
module vfd_serial_if
  import vfd_serial_pkg::*;
#(
  parameter int unsigned AD_CH       = 4,
  parameter int unsigned LEAD_BYTES  = 1,
  parameter int unsigned MAX_TIMINGS = 16,
  parameter int unsigned SLOTS       = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    sclk_i,
  input  logic                    sdata_i,
  output logic                    sdata_o,
  output logic                    sdata_oe_o,
  input  logic [AD_CH*BYTE_W-1:0] ad_data_i,
  output logic                    disp_on_o,
  output logic [1:0]              duty_code_o,
  output logic [1:0]              port_mode_o,
  output logic [2:0]              port_data_o,
  output logic [$clog2(MAX_TIMINGS)-1:0] timing_code_o,
  output logic                    three_byte_o,
  output logic [3:0]              digit_start_o,
  output logic                    ram_we_o,
  output logic [$clog2(MAX_TIMINGS)+$clog2(SLOTS)-1:0] ram_addr_o,
  output logic [BYTE_W-1:0]       ram_wdata_o
);
  localparam int unsigned OUT_BYTES = LEAD_BYTES + AD_CH;

  logic [1:0]        filt;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic              frame;

  vfd_glitch_filter #(.WIDTH(2), .SYNC_STAGES(2)) i_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({sdata_i, sclk_i}),
    .filt_o (filt)
  );

  vfd_serial_engine #(.AD_CH(AD_CH), .OUT_BYTES(OUT_BYTES)) i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_f_i   (filt[0]),
    .sdata_f_i  (filt[1]),
    .ad_data_i  (ad_data_i),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .rx_valid_o (rx_valid),
    .rx_byte_o  (rx_byte),
    .frame_o    (frame)
  );

  vfd_cmd_decoder #(.MAX_TIMINGS(MAX_TIMINGS), .SLOTS(SLOTS)) i_decoder (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_i       (frame),
    .rx_valid_i    (rx_valid),
    .rx_byte_i     (rx_byte),
    .disp_on_o     (disp_on_o),
    .duty_code_o   (duty_code_o),
    .port_mode_o   (port_mode_o),
    .port_data_o   (port_data_o),
    .timing_code_o (timing_code_o),
    .three_byte_o  (three_byte_o),
    .digit_start_o (digit_start_o),
    .ram_we_o      (ram_we_o),
    .ram_addr_o    (ram_addr_o),
    .ram_wdata_o   (ram_wdata_o)
  );
endmodule

// File: tb/test_vfd_serial_if.sv
`timescale 1ns/1ps
module test_vfd_serial_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdata = 1'b0;
  logic        sdata_o, sdata_oe;
  logic [31:0] ad_data = 32'hC3A5_5A81;
  logic        disp_on, three_byte, ram_we;
  logic [1:0]  duty, port_mode;
  logic [2:0]  port_data;
  logic [3:0]  timing_code, digit_start;
  logic [5:0]  ram_addr;
  logic [7:0]  ram_wdata;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  logic [7:0] mem [64];
  logic [7:0] rd [5];
  logic       oe_seen;

  always #2 clk = ~clk;

  vfd_serial_if i_vfd_serial_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdata_i(sdata),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe), .ad_data_i(ad_data),
    .disp_on_o(disp_on), .duty_code_o(duty), .port_mode_o(port_mode),
    .port_data_o(port_data), .timing_code_o(timing_code), .three_byte_o(three_byte),
    .digit_start_o(digit_start), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata)
  );

  always @(negedge clk) if (ram_we) begin
    mem[ram_addr] = ram_wdata;
    wr_cnt++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input int glitch_bit, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      sdata = b[i];
      wait_clk(3);
      if (i == glitch_bit) begin
        sclk = 1'b1; wait_clk(1); sclk = 1'b0; wait_clk(1);
      end
      wait_clk(3);
      got[i] = sdata_o;
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] dummy;
    send_bits(b, 8, -1, dummy);
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    wait_clk(8);
    oe_seen = sdata_oe;
    for (int k = 0; k < 5; k++) send_bits(8'h00, 8, -1, rd[k]);
  endtask

  task automatic close_frame();
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset();
    chk("R12", "display enable", disp_on, 0);
    chk("R12", "dimmer", duty, 0);
    chk("R12", "port mode", port_mode, 3);
    chk("R12", "port data", port_data, 0);
    chk("R12", "timing code", timing_code, 0);
    chk("R12", "width/start", {three_byte, digit_start}, 0);
    chk("R12", "no write", ram_we, 0);
    chk("R2", "oe idle", sdata_oe, 0);
  endtask

  task automatic t_readout();
    open_frame();
    chk("R4", "oe in output phase", oe_seen, 1);
    chk("R4", "filler byte", rd[0], 8'h00);
    chk("R4", "ch0", rd[1], 8'h81);
    chk("R4", "ch1", rd[2], 8'h5A);
    chk("R4", "ch2", rd[3], 8'hA5);
    chk("R4", "ch3", rd[4], 8'hC3);
    wait_clk(4);
    chk("R2", "oe off in input phase", sdata_oe, 0);
    close_frame();
    chk("R2", "oe off with cs high", sdata_oe, 0);
  endtask

  task automatic t_state();
    open_frame();
    send_byte(8'hD9);
    close_frame();
    chk("R1", "lsb-first state fields", {disp_on, duty}, 3'b110);
    chk("R6", "dimmer", duty, 2);
    chk("R6", "mode not yet active", port_mode, 3);
  endtask

  task automatic t_port();
    open_frame();
    send_byte(8'h85);
    close_frame();
    chk("R7", "port data", port_data, 5);
    chk("R7", "pending mode applied", port_mode, 1);
  endtask

  task automatic t_display4();
    open_frame();
    send_byte(8'hAE);
    send_byte(8'hE5);
    for (int i = 0; i < 8; i++) send_byte(8'h50 + 8'(i));
    close_frame();
    chk("R8", "timing code", timing_code, 14);
    chk("R9", "digit start / width", {three_byte, digit_start}, 5'h05);
    chk("R9", "write count", wr_cnt, 8);
    chk("R10", "first byte at top timing", mem[4], 8'h50);
    chk("R10", "slot 3 of top timing", mem[7], 8'h53);
    chk("R10", "next timing slot 0", mem[0], 8'h54);
    chk("R10", "last byte", mem[3], 8'h57);
  endtask

  task automatic t_display3();
    int base;
    open_frame();
    send_byte(8'hAD);
    send_byte(8'hF0);
    base = wr_cnt;
    for (int i = 0; i < 10; i++) send_byte(8'h30 + 8'(i));
    close_frame();
    chk("R9", "three-byte flag", three_byte, 1);
    chk("R9", "write count", wr_cnt - base, 10);
    chk("R10", "slot 2 of top timing", mem[10], 8'h32);
    chk("R10", "timing 1 slot 0", mem[4], 8'h33);
    chk("R10", "timing 0 slot 2", mem[2], 8'h38);
    chk("R10", "wrap to top timing", mem[8], 8'h39);
    base = wr_cnt;
    open_frame();
    send_byte(8'hC0);
    close_frame();
    chk("R9", "no write after cs high", wr_cnt - base, 0);
    chk("R9", "new frame decodes command", {disp_on, duty}, 0);
  endtask

  task automatic t_ignored();
    int base;
    base = wr_cnt;
    open_frame();
    send_byte(8'h3F);
    send_byte(8'h7F);
    close_frame();
    chk("R5", "bit7=0 no change", {disp_on, duty, port_mode, port_data, timing_code, three_byte, digit_start},
        {1'b0, 2'd0, 2'd1, 3'd5, 4'd13, 1'b1, 4'd0});
    chk("R5", "bit7=0 no write", wr_cnt - base, 0);
  endtask

  task automatic t_partial();
    logic [7:0] dummy;
    open_frame();
    send_bits(8'hFF, 4, -1, dummy);
    close_frame();
    open_frame();
    chk("R11", "filler after partial", rd[0], 8'h00);
    chk("R11", "ch0 after partial", rd[1], 8'h81);
    send_byte(8'hD4);
    close_frame();
    chk("R11", "clean decode after partial", {disp_on, duty}, 3'b101);
  endtask

  task automatic t_glitch();
    logic [7:0] dummy;
    open_frame();
    send_bits(8'hD6, 8, 3, dummy);
    close_frame();
    chk("R3", "sclk glitch ignored", {disp_on, duty}, 3'b101);
    open_frame();
    send_byte(8'h82);
    close_frame();
    chk("R3", "pending mode from glitched byte", port_mode, 2);
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(4);
    t_readout();
    t_state();
    t_port();
    t_display4();
    t_display3();
    t_ignored();
    t_partial();
    t_glitch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule